// File: doc/BRIEF.md
# March test sequence controller

This block runs a fixed two-pass march test on a word-wide SRAM through a plain memory port. After a start pulse it first fills every word with all-ones, visiting addresses from zero upward. It then returns to address zero and, at each address in ascending order, issues four operations before stepping on: write all-zeros, read back expecting zeros, write all-ones, read back expecting ones. Each word thus sees five operations. All bits of a word get the same value in the same cycle, so every column of the addressed row is exercised at once.

Every issued operation is accompanied by a valid strobe and a three-bit tag naming the operation. An external parametric comparator can use the pair to align its sampling windows to each write and read. Read data returns one cycle after the read strobe and is compared with the expected pattern. The first logical mismatch sets a sticky fail flag and records the failing address and operation tag. When the last read result has been checked, the block raises done.

Top module: `march_seq_ctrl`

## Requirements
- R1: After reset busy, done, fail, op_valid, mem_we and mem_re are all 0, and no operation is issued until start is pulsed.
- R2: The first 2^ADDR_W operations carry tag 0 (fill with ones). They write all-ones to addresses 0, 1, ... 2^ADDR_W-1 in ascending order.
- R3: After the fill pass the address wraps to 0. Each address in ascending order then receives tags 1, 2, 3, 4 in that order (write-zero, read-zero, write-one, read-one) before the address advances.
- R4: op_valid is high for exactly one cycle per operation. mem_we is high for tags 0, 1 and 3; mem_wdata is all-ones for tags 0 and 3 and all-zeros for tag 1. mem_re is high for tags 2 and 4. mem_we and mem_re are never high together, and neither is high without op_valid.
- R5: A run issues exactly 5*2^ADDR_W operations in consecutive cycles, starting the cycle after start. busy is high through these cycles and one further cycle for the last read check.
- R6: mem_rdata is sampled in the cycle after mem_re. It is compared with all-zeros for tag 2 and with all-ones for tag 4.
- R7: On the first mismatch, fail goes high and stays high, and fail_addr and fail_op take the address and tag of the failing read. Later mismatches in the same run do not change them.
- R8: done goes high in the cycle after the last read result is checked, with fail already final. It stays high, with busy low, until the next accepted start.
- R9: A start pulse while busy is high is ignored: the running sequence continues unchanged.
- R10: A start accepted while busy is low clears fail and begins a new run from the fill pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted when not busy) |
| mem_rdata | input | DATA_W | Read data from memory, one cycle after mem_re |
| mem_addr | output | ADDR_W | Word address |
| mem_we | output | 1 | Write enable |
| mem_re | output | 1 | Read enable |
| mem_wdata | output | DATA_W | Write data, all bits equal |
| op_valid | output | 1 | An operation is issued this cycle |
| op_tag | output | 3 | Operation tag: 0 fill-one, 1 write-zero, 2 read-zero, 3 write-one, 4 read-one |
| busy | output | 1 | Run in progress, including the final read check |
| done | output | 1 | Run finished, results final |
| fail | output | 1 | Sticky logical mismatch flag |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_op | output | 3 | Tag of the first mismatching read |

## Verification
The bench builds the block with ADDR_W = 3 and DATA_W = 8, so a whole run is 40 operations. With such short runs every address boundary, including the wrap between the two passes, can be reached many times within a few hundred cycles. The bench's memory model can force single bits of chosen words to stuck-at-zero or stuck-at-one. This makes the read-zero and read-one failures, and two failures in one run, happen at known addresses, so the captured address and tag can be predicted exactly. With eight-bit words, a fault in a single bit shows that the compare covers the whole word.

// File: rtl/march_pkg.sv
package march_pkg;

  typedef enum logic [2:0] {
    OP_INIT_W1 = 3'd0,
    OP_W0      = 3'd1,
    OP_R0      = 3'd2,
    OP_W1      = 3'd3,
    OP_R1      = 3'd4
  } march_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_INIT,
    ST_MAIN,
    ST_FIN
  } march_st_e;

  function automatic logic op_is_write(march_op_e op);
    return (op == OP_INIT_W1) || (op == OP_W0) || (op == OP_W1);
  endfunction

  // data polarity of an operation: written value or expected read value
  function automatic logic op_data_one(march_op_e op);
    return (op == OP_INIT_W1) || (op == OP_W1) || (op == OP_R1);
  endfunction

  function automatic march_op_e op_next(march_op_e op);
    case (op)
      OP_W0:   return OP_R0;
      OP_R0:   return OP_W1;
      OP_W1:   return OP_R1;
      default: return OP_W0;
    endcase
  endfunction

endpackage

// File: rtl/march_addr_ctr.sv
module march_addr_ctr #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr,
  output logic              at_last
);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n)   addr <= '0;
    else if (clr) addr <= '0;
    else if (inc) addr <= addr + 1'b1;
  end

  assign at_last = (addr == LAST);
endmodule

// File: rtl/march_op_seq.sv
module march_op_seq
  import march_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      go,
  input  logic      at_last,
  output march_st_e state,
  output march_op_e op,
  output logic      op_valid,
  output logic      addr_clr,
  output logic      addr_inc
);
  logic init_end;
  logic step_end;

  assign init_end = (state == ST_INIT) && at_last;
  assign step_end = (state == ST_MAIN) && (op == OP_R1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      op    <= OP_INIT_W1;
    end else if (go) begin
      state <= ST_INIT;
      op    <= OP_INIT_W1;
    end else begin
      case (state)
        ST_INIT: if (at_last) begin
          state <= ST_MAIN;
          op    <= OP_W0;
        end
        ST_MAIN: begin
          op <= op_next(op);
          if (step_end && at_last) state <= ST_FIN;
        end
        default: ;
      endcase
    end
  end

  assign op_valid = (state == ST_INIT) || (state == ST_MAIN);
  assign addr_clr = go || init_end;
  assign addr_inc = ((state == ST_INIT) && !at_last) || step_end;
endmodule

// File: rtl/march_rd_check.sv
module march_rd_check
  import march_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              rd_issue,
  input  march_op_e         rd_op,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rdata,
  output logic              pend,
  output logic              mismatch,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [2:0]        fail_op
);
  march_op_e         op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] expect_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      op_q   <= OP_R0;
      addr_q <= '0;
    end else begin
      pend <= rd_issue;
      if (rd_issue) begin
        op_q   <= rd_op;
        addr_q <= rd_addr;
      end
    end
  end

  assign expect_word = {DATA_W{op_data_one(op_q)}};
  assign mismatch    = pend && (rdata != expect_word);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_op   <= 3'd0;
    end else if (mismatch && !fail) begin
      fail      <= 1'b1;
      fail_addr <= addr_q;
      fail_op   <= op_q;
    end
  end
endmodule

// File: rtl/march_seq_ctrl.sv
module march_seq_ctrl
  import march_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              op_valid,
  output logic [2:0]        op_tag,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [2:0]        fail_op
);
  march_st_e state;
  march_op_e op;
  logic      go;
  logic      at_last;
  logic      addr_clr;
  logic      addr_inc;
  logic      rd_pend;
  logic      rd_mismatch;

  assign go = start && !busy;

  march_op_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .at_last  (at_last),
    .state    (state),
    .op       (op),
    .op_valid (op_valid),
    .addr_clr (addr_clr),
    .addr_inc (addr_inc)
  );

  march_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (addr_clr),
    .inc     (addr_inc),
    .addr    (mem_addr),
    .at_last (at_last)
  );

  assign mem_we    = op_valid && op_is_write(op);
  assign mem_re    = op_valid && !op_is_write(op);
  assign mem_wdata = {DATA_W{op_data_one(op)}};
  assign op_tag    = op;

  march_rd_check #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (go),
    .rd_issue  (mem_re),
    .rd_op     (op),
    .rd_addr   (mem_addr),
    .rdata     (mem_rdata),
    .pend      (rd_pend),
    .mismatch  (rd_mismatch),
    .fail      (fail),
    .fail_addr (fail_addr),
    .fail_op   (fail_op)
  );

  assign busy = op_valid || ((state == ST_FIN) && rd_pend);
  assign done = (state == ST_FIN) && !rd_pend;
endmodule

// File: rtl/march_seq_chk.sv
module march_seq_chk
  import march_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic [ADDR_W-1:0] fail_addr,
  input logic [2:0]        fail_op,
  input logic              op_valid,
  input logic [2:0]        op_tag,
  input logic              mem_we,
  input logic              mem_re
);
  logic restart;
  assign restart = start && !busy;

  p_we_re_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  p_strobe_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> op_valid);

  p_read_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> (op_tag == OP_R0 || op_tag == OP_R1));

  p_valid_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> busy);

  p_r0_after_w0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_tag == OP_W0) |=> (op_valid && op_tag == OP_R0));

  p_r1_after_w1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_tag == OP_W1) |=> (op_valid && op_tag == OP_R1));

  p_fail_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !restart) |=> fail);

  p_capture_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !restart) |=> ($stable(fail_addr) && $stable(fail_op)));

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !op_valid));

  p_done_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  p_ignore_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && op_valid && op_tag == OP_W0) |=> (op_valid && op_tag == OP_R0));

  p_restart_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!fail && busy && op_valid && op_tag == OP_INIT_W1));
endmodule

bind march_seq_ctrl march_seq_chk #(.ADDR_W(ADDR_W)) u_seq_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .fail      (fail),
  .fail_addr (fail_addr),
  .fail_op   (fail_op),
  .op_valid  (op_valid),
  .op_tag    (op_tag),
  .mem_we    (mem_we),
  .mem_re    (mem_re)
);

// File: tb/sim_march_seq_ctrl.sv
`timescale 1ns/1ps
module sim_march_seq_ctrl;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int NOPS = 5 * DEPTH;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [DW-1:0] mem_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_we, mem_re, op_valid, busy, done, fail;
  logic [DW-1:0] mem_wdata;
  logic [2:0]    op_tag, fail_op;
  logic [AW-1:0] fail_addr;

  always #2 clk = ~clk;

  march_seq_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .op_valid(op_valid), .op_tag(op_tag),
    .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr),
    .fail_op(fail_op)
  );

  // memory model with per-word stuck-at masks
  logic [DW-1:0] mem  [DEPTH];
  logic [DW-1:0] sa0  [DEPTH];
  logic [DW-1:0] sa1  [DEPTH];

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= (mem[mem_addr] | sa1[mem_addr]) & ~sa0[mem_addr];
  end

  int n_chk = 0;
  int n_bad = 0;
  int n_ops = 0;
  int seq_err = 0;
  int busy_cyc = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: restates the operation order from R2, R3, R4
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_cyc++;
      if (op_valid) begin
        int m;
        int e_addr;
        int e_tag;
        if (n_ops < DEPTH) begin
          e_addr = n_ops; e_tag = 0;
        end else begin
          m = n_ops - DEPTH; e_addr = m / 4; e_tag = 1 + (m % 4);
        end
        if (n_ops >= NOPS || int'(mem_addr) != e_addr || int'(op_tag) != e_tag) begin
          seq_err++;
          $display("  op %0d: addr %0d tag %0d, wanted addr %0d tag %0d",
                   n_ops, mem_addr, op_tag, e_addr, e_tag);
        end
        if (mem_we != (e_tag == 0 || e_tag == 1 || e_tag == 3)) seq_err++;
        if (mem_re != (e_tag == 2 || e_tag == 4)) seq_err++;
        if (mem_we && mem_wdata != ((e_tag == 1) ? '0 : {DW{1'b1}})) seq_err++;
        n_ops++;
      end else if (mem_we || mem_re) begin
        seq_err++;
      end
    end
  end

  task automatic clear_faults();
    for (int i = 0; i < DEPTH; i++) begin sa0[i] = '0; sa1[i] = '0; end
  endtask

  task automatic run_march(input int poke_at);
    n_ops = 0; seq_err = 0; busy_cyc = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int c = 1; c < 1000 && !done; c++) begin
      if (c == poke_at) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !done && !fail && !op_valid && !mem_we && !mem_re, "R1 reset state",
          {busy, done, fail, op_valid, mem_we, mem_re}, 0);
    check(n_ops == 0, "R1 no op before start", n_ops, 0);
  endtask

  task automatic t_clean();
    clear_faults();
    run_march(0);
    check(seq_err == 0, "R2 R3 R4 operation order and strobes", seq_err, 0);
    check(n_ops == NOPS, "R5 operation count", n_ops, NOPS);
    check(busy_cyc == NOPS + 1, "R5 busy span", busy_cyc, NOPS + 1);
    check(done && !busy && !fail, "R8 done clean", {done, busy, fail}, 3'b100);
    begin
      int bad = 0;
      for (int i = 0; i < DEPTH; i++) if (mem[i] != {DW{1'b1}}) bad++;
      check(bad == 0, "R3 all words end at ones", bad, 0);
    end
    repeat (5) @(negedge clk);
    check(n_ops == NOPS && done && !busy, "R8 done holds with no further ops", n_ops, NOPS);
  endtask

  task automatic t_stuck1();
    clear_faults();
    sa1[5] = 8'h10;
    run_march(0);
    check(fail == 1'b1, "R6 read-zero mismatch flagged", fail, 1);
    check(fail_addr == 3'd5, "R7 fail_addr read-zero", fail_addr, 5);
    check(fail_op == 3'd2, "R7 fail_op read-zero", fail_op, 2);
  endtask

  task automatic t_stuck0();
    clear_faults();
    sa0[2] = 8'h01;
    run_march(0);
    check(fail == 1'b1, "R10 R6 read-one mismatch after restart", fail, 1);
    check(fail_addr == 3'd2, "R7 fail_addr read-one", fail_addr, 2);
    check(fail_op == 3'd4, "R7 fail_op read-one", fail_op, 4);
    check(seq_err == 0 && n_ops == NOPS, "R5 order unaffected by fail", seq_err, 0);
  endtask

  task automatic t_two_faults();
    clear_faults();
    sa0[1] = 8'h80;
    sa1[6] = 8'h02;
    run_march(0);
    check(fail_addr == 3'd1 && fail_op == 3'd4, "R7 first mismatch kept",
          {fail_addr, fail_op}, {3'd1, 3'd4});
  endtask

  task automatic t_restart_clears();
    clear_faults();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(!fail && busy, "R10 start clears fail", {fail, busy}, 2'b01);
    for (int c = 0; c < 1000 && !done; c++) @(negedge clk);
    check(!fail && done, "R10 clean rerun", {fail, done}, 2'b01);
  endtask

  task automatic t_ignore_start();
    clear_faults();
    run_march(13);
    check(seq_err == 0 && n_ops == NOPS, "R9 start while busy ignored", seq_err, 0);
    check(busy_cyc == NOPS + 1, "R9 run length unchanged", busy_cyc, NOPS + 1);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'h5A;
    clear_faults();
    t_reset();
    t_clean();
    t_stuck1();
    t_stuck0();
    t_two_faults();
    t_restart_clears();
    t_ignore_start();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule